// File: doc/BRIEF.md
# Count-Based Statistical Victim Selector for a Four-Way Cache

This block holds the replacement state of a four-way set-associative cache and decides which way gets evicted on a miss. It does not use recency order. Instead it models the references to each way as a Poisson process.

Every way keeps a saturating local access count and a fixed-point running-mean rate estimate. Every set keeps one global access count. The score of a way combines its rate and its count, and it stands for how likely that way is to be referenced again. The way with the smallest score is the eviction candidate. Among equal scores, a free-running linear-feedback shift register picks one pseudo-randomly. Ways that have never been filled are always taken first.

The cache controller drives one access per lookup. Each access carries the set, whether it hit, and the way that hit. When a fill is needed, the controller raises a victim request with the set. One cycle later it receives the registered victim way. That same request also marks the way as filled and clears its local count. Tags, data and miss handling stay outside the block.

Top module: `rate_victim_select`

## Requirements
- R1: After reset, `vic_valid` is 0. Every way of every set is unfilled, every local and global count is 0, and every rate estimate equals 1.0 (fixed-point value 4, with 2 fraction bits).
- R2: `vic_valid` is 1 in exactly the cycle after a cycle with `vic_req` high, and 0 after any cycle without a request. The value of `vic_way` is valid while `vic_valid` is 1.
- R3: If the requested set has any unfilled way, the victim is the unfilled way with the lowest index. A request marks its victim as filled.
- R4: A hit increments the local count of the hit way. The count saturates at 15 and never wraps.
- R5: The global count of a set increases on every access to that set, hit or miss. When an access finds the global count at 63, the count becomes 0 instead. In that case all four local counts of the set are halved (shift right by one), applied after that access's own increment.
- R6: On a hit, the rate estimate of the hit way becomes (old_rate + 4*new_count) >> 1. Here new_count is the incremented, unhalved count, and the rate has 2 fraction bits.
- R7: A way's score is (rate >> 2) + local count. When all four ways of the requested set are filled, the victim has the smallest score in the set.
- R8: Among ways tied at the smallest score, the choice is the tied way whose position, counted in ascending way order from 0, equals the two low LFSR bits modulo the number of tied ways. The LFSR advances every cycle, so repeated tied requests spread over several ways.
- R9: Eviction clears the victim's local count to 0 and leaves its rate estimate unchanged.
- R10: Accesses and requests to one set do not change the state of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | $clog2(SETS) | Set of the access |
| acc_hit | input | 1 | The access hit |
| acc_way | input | 2 | Way that hit (used only when acc_hit is 1) |
| vic_req | input | 1 | Victim request |
| vic_set | input | $clog2(SETS) | Set of the victim request |
| vic_valid | output | 1 | Registered: a victim is presented |
| vic_way | output | 2 | Registered victim way |

## Verification
The hardest situation to reach is the global-count rollover, where halving the local counts reorders the scores. It needs 64 accesses to a single set, interleaved with hits and evictions that leave distinct counts behind. The bench reaches it by aiming most of a long random stream at four sets, so each one rolls over many times. A reference model tracks every count and rate and yields the set of legal victims for each request. Directed sequences add a case with a unique, hand-derived minimum, an eviction that clears a count, and a fully tied set that must produce more than one distinct victim.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  localparam int WAYS = 4;
  typedef logic [1:0] way_t;
endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[14:0], fb};
  end

  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (state != 16'h0));
endmodule

// File: rtl/rvs_state.sv
module rvs_state import rvs_pkg::*; #(
  parameter int SETS      = 16,
  parameter int CNT_W     = 4,
  parameter int GCNT_W    = 6,
  parameter int FRAC      = 2,
  parameter int RATE_W    = CNT_W + FRAC,
  parameter int INIT_RATE = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_valid,
  input  logic [$clog2(SETS)-1:0]      acc_set,
  input  logic                         acc_hit,
  input  way_t                         acc_way,
  input  logic                         evict_en,
  input  logic [$clog2(SETS)-1:0]      evict_set,
  input  way_t                         evict_way,
  input  logic [$clog2(SETS)-1:0]      rd_set,
  output logic [WAYS-1:0][CNT_W-1:0]   rd_cnt,
  output logic [WAYS-1:0][RATE_W-1:0]  rd_rate,
  output logic [WAYS-1:0]              rd_valid
);
  localparam logic [CNT_W-1:0]  CMAX = {CNT_W{1'b1}};
  localparam logic [GCNT_W-1:0] GMAX = {GCNT_W{1'b1}};
  localparam logic [RATE_W-1:0] RINIT = RATE_W'(INIT_RATE);

  logic [CNT_W-1:0]  cnt_q   [SETS][WAYS];
  logic [RATE_W-1:0] rate_q  [SETS][WAYS];
  logic              valid_q [SETS][WAYS];
  logic [GCNT_W-1:0] gcnt_q  [SETS];

  // next values for the set under access
  logic                       wrap;
  logic [WAYS-1:0][CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0]           hit_cnt;
  logic [RATE_W:0]            rate_sum;
  logic [RATE_W-1:0]          rate_nxt;

  always_comb begin
    wrap    = (gcnt_q[acc_set] == GMAX);
    hit_cnt = cnt_q[acc_set][acc_way];
    if (hit_cnt != CMAX) hit_cnt = hit_cnt + 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      cnt_nxt[w] = (acc_hit && acc_way == way_t'(w)) ? hit_cnt : cnt_q[acc_set][w];
      if (wrap) cnt_nxt[w] = cnt_nxt[w] >> 1;
    end
    rate_sum = {1'b0, rate_q[acc_set][acc_way]} + ((RATE_W+1)'(hit_cnt) << FRAC);
    rate_nxt = rate_sum[RATE_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        gcnt_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          cnt_q[s][w]   <= '0;
          rate_q[s][w]  <= RINIT;
          valid_q[s][w] <= 1'b0;
        end
      end
    end else begin
      if (acc_valid) begin
        for (int w = 0; w < WAYS; w++) cnt_q[acc_set][w] <= cnt_nxt[w];
        gcnt_q[acc_set] <= wrap ? '0 : gcnt_q[acc_set] + 1'b1;
        if (acc_hit) rate_q[acc_set][acc_way] <= rate_nxt;
      end
      if (evict_en) begin
        cnt_q[evict_set][evict_way]   <= '0;
        valid_q[evict_set][evict_way] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_cnt[w]   = cnt_q[rd_set][w];
      rd_rate[w]  = rate_q[rd_set][w];
      rd_valid[w] = valid_q[rd_set][w];
    end
  end

  assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit && !evict_en && cnt_q[acc_set][acc_way] == CMAX
     && gcnt_q[acc_set] != GMAX)
    |=> cnt_q[$past(acc_set)][$past(acc_way)] == CMAX);

  assert_global_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && gcnt_q[acc_set] == GMAX) |=> gcnt_q[$past(acc_set)] == '0);

  assert_evict_clears_R9: assert property (@(posedge clk) disable iff (rst)
    evict_en |=> (cnt_q[$past(evict_set)][$past(evict_way)] == '0
                  && valid_q[$past(evict_set)][$past(evict_way)]));
endmodule

// File: rtl/rvs_score.sv
module rvs_score import rvs_pkg::*; #(
  parameter int CNT_W  = 4,
  parameter int FRAC   = 2,
  parameter int RATE_W = CNT_W + FRAC,
  parameter int SW     = CNT_W + 1
) (
  input  logic [WAYS-1:0][CNT_W-1:0]  cnt,
  input  logic [WAYS-1:0][RATE_W-1:0] rate,
  output logic [WAYS-1:0][SW-1:0]     score
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign score[w] = SW'(rate[w][RATE_W-1:FRAC]) + SW'(cnt[w]);
  end
endmodule

// File: rtl/rvs_pick.sv
module rvs_pick import rvs_pkg::*; #(
  parameter int SW = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic [WAYS-1:0]         valid,
  input  logic [WAYS-1:0][SW-1:0] scores,
  input  logic [1:0]              rnd,
  output way_t                    pick_way,
  output logic                    vic_valid,
  output way_t                    vic_way
);
  logic [SW-1:0]   min_s;
  logic [WAYS-1:0] tie;
  logic [2:0]      ntie;
  logic [2:0]      sel;
  logic [2:0]      k;

  always_comb begin
    min_s = scores[0];
    for (int w = 1; w < WAYS; w++)
      if (scores[w] < min_s) min_s = scores[w];
    tie  = '0;
    ntie = '0;
    for (int w = 0; w < WAYS; w++)
      if (scores[w] == min_s) begin
        tie[w] = 1'b1;
        ntie   = ntie + 3'd1;
      end
    sel      = {1'b0, rnd} % ntie;
    pick_way = '0;
    k        = '0;
    if (!(&valid)) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!valid[w]) pick_way = way_t'(w);
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (tie[w]) begin
          if (k == sel) pick_way = way_t'(w);
          k = k + 3'd1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
    end else begin
      vic_valid <= req;
      if (req) vic_way <= pick_way;
    end
  end

  function automatic logic none_lower(input logic [WAYS-1:0][SW-1:0] s, input way_t w);
    none_lower = 1'b1;
    for (int i = 0; i < WAYS; i++)
      if (s[i] < s[w]) none_lower = 1'b0;
  endfunction

  function automatic logic bit_at(input logic [WAYS-1:0] v, input way_t w);
    bit_at = v[w];
  endfunction

  assert_vic_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req |=> vic_valid);
  assert_vic_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req |=> !vic_valid);
  assert_invalid_first_R3: assert property (@(posedge clk) disable iff (rst)
    (req && !(&valid)) |=> !bit_at($past(valid), vic_way));
  assert_lowest_score_R7: assert property (@(posedge clk) disable iff (rst)
    (req && (&valid)) |=> none_lower($past(scores), vic_way));
endmodule

// File: rtl/rate_victim_select.sv
module rate_victim_select import rvs_pkg::*; #(
  parameter int SETS      = 16,
  parameter int CNT_W     = 4,
  parameter int GCNT_W    = 6,
  parameter int FRAC      = 2,
  parameter int INIT_RATE = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic [$clog2(SETS)-1:0] acc_set,
  input  logic                    acc_hit,
  input  logic [1:0]              acc_way,
  input  logic                    vic_req,
  input  logic [$clog2(SETS)-1:0] vic_set,
  output logic                    vic_valid,
  output logic [1:0]              vic_way
);
  localparam int RATE_W = CNT_W + FRAC;
  localparam int SW     = CNT_W + 1;

  logic [WAYS-1:0][CNT_W-1:0]  rd_cnt;
  logic [WAYS-1:0][RATE_W-1:0] rd_rate;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0][SW-1:0]     scores;
  logic [15:0]                 lfsr;
  way_t                        pick_way;

  rvs_lfsr u_lfsr (.clk(clk), .rst(rst), .state(lfsr));

  rvs_state #(
    .SETS(SETS), .CNT_W(CNT_W), .GCNT_W(GCNT_W), .FRAC(FRAC),
    .RATE_W(RATE_W), .INIT_RATE(INIT_RATE)
  ) u_state (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_hit(acc_hit), .acc_way(acc_way),
    .evict_en(vic_req), .evict_set(vic_set), .evict_way(pick_way),
    .rd_set(vic_set), .rd_cnt(rd_cnt), .rd_rate(rd_rate), .rd_valid(rd_valid)
  );

  rvs_score #(.CNT_W(CNT_W), .FRAC(FRAC), .RATE_W(RATE_W), .SW(SW)) u_score (
    .cnt(rd_cnt), .rate(rd_rate), .score(scores)
  );

  rvs_pick #(.SW(SW)) u_pick (
    .clk(clk), .rst(rst), .req(vic_req), .valid(rd_valid), .scores(scores),
    .rnd(lfsr[1:0]), .pick_way(pick_way), .vic_valid(vic_valid), .vic_way(vic_way)
  );
endmodule

// File: tb/rate_victim_select_bench.sv
module rate_victim_select_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_valid, acc_hit, vic_req;
  logic [3:0] acc_set, vic_set;
  logic [1:0] acc_way;
  logic       vic_valid;
  logic [1:0] vic_way;

  int n_chk = 0;
  int n_bad = 0;
  int m_c [16][4];
  int m_r [16][4];
  bit m_v [16][4];
  int m_g [16];

  always #10 clk = ~clk;

  rate_victim_select u_rate_victim_select (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_way(acc_way), .vic_req(vic_req), .vic_set(vic_set),
    .vic_valid(vic_valid), .vic_way(vic_way)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input int s);
    logic [3:0] m;
    int sc [4];
    int mn;
    m = '0;
    for (int w = 0; w < 4; w++)
      if (!m_v[s][w]) begin
        m[w] = 1'b1;
        return m;
      end
    mn = 1000;
    for (int w = 0; w < 4; w++) begin
      sc[w] = m_r[s][w] / 4 + m_c[s][w];
      if (sc[w] < mn) mn = sc[w];
    end
    for (int w = 0; w < 4; w++) if (sc[w] == mn) m[w] = 1'b1;
    return m;
  endfunction

  function automatic bit any_invalid(input int s);
    for (int w = 0; w < 4; w++) if (!m_v[s][w]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_acc(input int s, input bit hit, input int w);
    int nc;
    @(negedge clk);
    acc_valid = 1'b1; acc_set = 4'(s); acc_hit = hit; acc_way = 2'(w);
    @(negedge clk);
    acc_valid = 1'b0;
    chk(vic_valid == 1'b0, "R2 idle after access", int'(vic_valid), 0);
    if (hit) begin
      nc = (m_c[s][w] < 15) ? m_c[s][w] + 1 : 15;
      m_r[s][w] = (m_r[s][w] + nc * 4) / 2;
      m_c[s][w] = nc;
    end
    if (m_g[s] == 63) begin
      m_g[s] = 0;
      for (int i = 0; i < 4; i++) m_c[s][i] = m_c[s][i] / 2;
    end else m_g[s]++;
  endtask

  task automatic do_req(input int s, output int got);
    logic [3:0] m;
    bit inv;
    m = exp_mask(s);
    inv = any_invalid(s);
    @(negedge clk);
    vic_req = 1'b1; vic_set = 4'(s);
    @(negedge clk);
    vic_req = 1'b0;
    got = int'(vic_way);
    chk(vic_valid == 1'b1, "R2 valid after request", int'(vic_valid), 1);
    chk(m[vic_way] == 1'b1, inv ? "R3 unfilled first" : "R7/R8 lowest score",
        got, int'(m));
    m_v[s][vic_way] = 1'b1;
    m_c[s][vic_way] = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int got;
    int seen;
    void'($urandom(32'd12345));
    rst = 1'b1; acc_valid = 0; acc_hit = 0; acc_set = 0; acc_way = 0;
    vic_req = 0; vic_set = 0;
    for (int s = 0; s < 16; s++) begin
      m_g[s] = 0;
      for (int w = 0; w < 4; w++) begin m_c[s][w] = 0; m_r[s][w] = 4; m_v[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vic_valid == 1'b0, "R1 reset vic_valid", int'(vic_valid), 0);

    // R1 / R3: fresh set fills in ascending way order
    for (int w = 0; w < 4; w++) begin
      do_req(3, got);
      chk(got == w, "R3 fill order", got, w);
    end
    // R8: fully tied set, several different victims expected
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      do_req(3, got);
      seen |= (1 << got);
    end
    chk($countones(seen) >= 2, "R8 tie spread", $countones(seen), 2);

    // R6 / R7: distinct scores, unique minimum on way 1
    for (int w = 0; w < 4; w++) do_req(7, got);
    repeat (3) do_acc(7, 1, 0);
    do_acc(7, 1, 1);
    repeat (6) do_acc(7, 1, 2);
    repeat (2) do_acc(7, 1, 3);
    do_req(7, got);
    chk(got == 1, "R7 unique lowest", got, 1);
    // R9: cleared count keeps it lowest
    do_req(7, got);
    chk(got == 1, "R9 evicted count cleared", got, 1);
    // R10: other set activity leaves set 7 untouched
    repeat (5) do_acc(8, 0, 0);
    do_req(8, got);
    chk(got == 0, "R10 other set fresh", got, 0);
    do_req(7, got);
    chk(got == 1, "R10 set 7 unchanged", got, 1);

    // R4: saturate way 0 of set 9
    for (int w = 0; w < 4; w++) do_req(9, got);
    repeat (20) do_acc(9, 1, 0);
    do_acc(9, 1, 1);
    do_req(9, got);
    chk(got != 0, "R4 saturated way kept", got, 2);

    // R5: drive set 11 across a global rollover
    for (int w = 0; w < 4; w++) do_req(11, got);
    repeat (4) do_acc(11, 1, 0);
    do_acc(11, 1, 1);
    do_acc(11, 1, 2);
    repeat (2) do_acc(11, 1, 3);
    repeat (55) do_acc(11, 0, 0);
    do_acc(11, 1, 1);
    do_req(11, got);
    chk(got == 2, "R5 halving after rollover", got, 2);

    // random stream concentrated on four sets
    for (int i = 0; i < 4000; i++) begin
      int s, op, w;
      s  = ($urandom % 8 < 7) ? int'($urandom % 4) : int'($urandom % 16);
      op = int'($urandom % 8);
      w  = int'($urandom % 4);
      if (op < 2) do_req(s, got);
      else if (op < 6 && m_v[s][w]) do_acc(s, 1, w);
      else do_acc(s, 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule